// File: doc/BRIEF.md
# GPIO Pin Interrupt Event Detector

This block decides, for every GPIO pin that is configured as an input, whether an interrupt event happens in the current clock cycle. It looks at four things for each pin: the synchronized level now, the level sampled one cycle earlier, a 2-bit sensitivity code, and a per-pin override bit that makes the pin fire on any change of level. From these it drives a combinational vector of set pulses, one bit per pin.

Each pulse is ORed into a sticky interrupt status register. Software clears bits of that register with a write-one-to-clear vector. The pins reach the block already synchronized. Masking, bus decoding and the interrupt output lines sit outside the block.

The block keeps a register of previous levels. It loads every pin's level into that register on every cycle, including pins driven as outputs. When a pin later turns from output to input, its history is therefore current and no false edge appears.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin whose direction bit is 1 (output) never produces a set pulse, whatever its level, code or override bit.
- R2: When a pin's override bit is 1, any difference between its current level and its previous sample produces a set pulse, whichever direction the change goes and whatever the 2-bit code holds.
- R3: When a pin's override bit is 1 and its level equals the previous sample, no set pulse occurs, even if the 2-bit code names a level condition that is true.
- R4: Code 2'b10 (upper bit 1 = edge mode, lower bit 0) pulses only in a cycle where the previous sample is 0 and the level is 1.
- R5: Code 2'b11 pulses only in a cycle where the previous sample is 1 and the level is 0.
- R6: Code 2'b00 (upper bit 0 = level mode) pulses in every cycle in which the pin level is 0.
- R7: Code 2'b01 pulses in every cycle in which the pin level is 1.
- R8: The previous-level register loads every pin's level on every clock edge, whatever the pin's direction. Turning an output pin into an edge-coded input at an unchanged level therefore gives no pulse.
- R9: Pin n takes its mode from bit 2n+1 and its polarity from bit 2n of the 64-bit sensitivity field, and pins do not interact.
- R10: The status register takes (status AND NOT clear) OR pulses at each edge. A pulse therefore wins over a clear of the same bit in the same cycle, and a clear with no pulse drops the bit.
- R11: A level-coded pin whose condition still holds sets its status bit again after software clears it.
- R12: Synchronous active-low reset zeroes the status register and the previous-level register. In the first cycle after reset, an input pin held at 1 therefore reads as a rising change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| pin_is_out | input | 32 | Direction per pin, 1 = output |
| sense_cfg | input | 64 | Per-pin code: bit 2n+1 mode (1 edge), bit 2n polarity |
| both_edge | input | 32 | Per-pin override, 1 = fire on any change |
| sts_clr | input | 32 | Write-one-to-clear strobe for the status bits |
| set_pulse | output | 32 | Event pulses for the current cycle |
| irq_status | output | 32 | Sticky interrupt status |

## Verification
The bench focuses on the places where a plausible design goes quietly wrong.

- **Turning an output into an input.** An output pin toggles and is then turned into a rising-edge input at a level that does not change. A design that stops updating its history for outputs raises a false pulse here.
- **Clear and pulse in the same cycle.** A clear meets a live low-level condition. A design that gives the clear priority loses the interrupt for a cycle.
- **Override against a true level code.** The override bit is set while the level code would fire. A design that lets the code leak past the override pulses on a steady pin.
- **Bit-pair ordering and reset history.** A mixed per-pin configuration catches a swapped mode/polarity pair. A first cycle with pins high after reset catches a history register that was never cleared.

// File: rtl/gpio_irq_pkg.sv
// Package: shared encodings for the GPIO interrupt event detector.
// Assumes each pin owns one 2-bit code; the upper bit selects edge mode.
package gpio_irq_pkg;

    localparam int SENSE_W = 2;

    // Per-pin sensitivity code: {mode, polarity}
    typedef enum logic [SENSE_W-1:0] {
        SENSE_LVL_LO  = 2'b00,
        SENSE_LVL_HI  = 2'b01,
        SENSE_EDGE_UP = 2'b10,
        SENSE_EDGE_DN = 2'b11
    } sense_e;

endpackage

// File: rtl/gpio_irq_history.sv
// Module: previous-level register for all pins.
// Loads every pin's level at every edge regardless of direction, so a
// pin turned from output to input starts with a current history.
module gpio_irq_history #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_now,
    output logic [NPINS-1:0] lvl_prev
);

    // Capture the level of each pin for the next cycle's comparison
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl_now;
    end

endmodule

// File: rtl/gpio_irq_pin_eval.sv
// Module: event decision for one pin.
// Assumes levels are already synchronized. The override bit takes
// precedence over the code, and output pins never fire.
module gpio_irq_pin_eval
    import gpio_irq_pkg::*;
(
    input  logic   cur_lvl,
    input  logic   old_lvl,
    input  logic   is_output,
    input  logic   any_edge,
    input  sense_e code,
    output logic   hit
);

    logic changed;

    // Detect a level difference against the previous sample
    always_comb changed = cur_lvl ^ old_lvl;

    // Select the event condition from override and code
    always_comb begin
        hit = 1'b0;
        if (!is_output) begin
            if (any_edge) begin
                hit = changed;
            end else begin
                unique case (code)
                    SENSE_LVL_LO:  hit = ~cur_lvl;
                    SENSE_LVL_HI:  hit = cur_lvl;
                    SENSE_EDGE_UP: hit = changed & cur_lvl;
                    SENSE_EDGE_DN: hit = changed & ~cur_lvl;
                    default:       hit = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Module: sticky interrupt status with write-one-to-clear.
// Assumes pulses and clears arrive in the same cycle. A pulse wins.
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] set_vec,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] sts
);

    // Merge new events into the status after removing cleared bits
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the GPIO interrupt event detector.
// Builds one evaluator per pin. Pin n reads bits 2n+1 (mode) and 2n
// (polarity) of the sensitivity field. Inputs are assumed synchronous.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int CFG_W = NPINS * SENSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] pin_is_out,
    input  logic [CFG_W-1:0] sense_cfg,
    input  logic [NPINS-1:0] both_edge,
    input  logic [NPINS-1:0] sts_clr,
    output logic [NPINS-1:0] set_pulse,
    output logic [NPINS-1:0] irq_status
);

    logic [NPINS-1:0] prev_lvl;

    gpio_irq_history #(.NPINS(NPINS)) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_now  (pin_lvl),
        .lvl_prev (prev_lvl)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_irq_pin_eval eval_i (
            .cur_lvl   (pin_lvl[g]),
            .old_lvl   (prev_lvl[g]),
            .is_output (pin_is_out[g]),
            .any_edge  (both_edge[g]),
            .code      (sense_e'(sense_cfg[g*SENSE_W +: SENSE_W])),
            .hit       (set_pulse[g])
        );
    end

    gpio_irq_status #(.NPINS(NPINS)) sts_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_pulse),
        .clr_vec (sts_clr),
        .sts     (irq_status)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
// Module: property checker for gpio_irq_detect, attached by bind.
// Sees the previous-level register so it can judge edge decisions.
module gpio_irq_detect_chk #(
    parameter int NPINS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPINS-1:0]   pin_lvl,
    input logic [NPINS-1:0]   pin_is_out,
    input logic [2*NPINS-1:0] sense_cfg,
    input logic [NPINS-1:0]   both_edge,
    input logic [NPINS-1:0]   sts_clr,
    input logic [NPINS-1:0]   set_pulse,
    input logic [NPINS-1:0]   irq_status,
    input logic [NPINS-1:0]   prev_lvl
);

    logic [NPINS-1:0] mode_v;
    logic [NPINS-1:0] pol_v;

    // Split the sensitivity field into mode and polarity vectors
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            mode_v[i] = sense_cfg[2*i+1];
            pol_v[i]  = sense_cfg[2*i];
        end
    end

    // R1
    out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse & pin_is_out) == '0);

    // R3
    stable_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((both_edge | mode_v) & ~pin_is_out & ~(pin_lvl ^ prev_lvl) & set_pulse) == '0);

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~mode_v & ~both_edge & ~pin_is_out & ~(pin_lvl ^ pol_v) & ~set_pulse) == '0);

    // R8
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_lvl == $past(pin_lvl));

    // R10
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_status & $past(set_pulse)) == $past(set_pulse));

    // R10
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_status & $past(sts_clr & ~set_pulse)) == '0);

    // R10
    no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_status & ~$past(irq_status) & ~$past(set_pulse)) == '0);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_lvl    (pin_lvl),
    .pin_is_out (pin_is_out),
    .sense_cfg  (sense_cfg),
    .both_edge  (both_edge),
    .sts_clr    (sts_clr),
    .set_pulse  (set_pulse),
    .irq_status (irq_status),
    .prev_lvl   (prev_lvl)
);

// File: tb/gpio_irq_detect_tb_top.sv
// Bench: scoreboard for gpio_irq_detect. The driver pushes the expected
// pulse and status vectors for each cycle, and the monitor pops and compares them.
module gpio_irq_detect_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] C_RISE = 64'hAAAA_AAAA_AAAA_AAAA;
    localparam logic [63:0] C_FALL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] C_LOW  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] C_HIGH = 64'h5555_5555_5555_5555;
    localparam logic [31:0] ONES   = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = ONES;
    logic [31:0] pin_is_out = ONES;
    logic [63:0] sense_cfg = '0;
    logic [31:0] both_edge = '0;
    logic [31:0] sts_clr = '0;
    logic [31:0] set_pulse;
    logic [31:0] irq_status;

    int n_total = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] e_set;
        logic [31:0] e_sts;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] m_prev = '0;
    logic [31:0] m_sts = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_detect dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .pin_is_out (pin_is_out),
        .sense_cfg  (sense_cfg),
        .both_edge  (both_edge),
        .sts_clr    (sts_clr),
        .set_pulse  (set_pulse),
        .irq_status (irq_status)
    );

    // Expected pulse for one pin, taken from the requirement wording
    function automatic logic want_hit(logic cur, logic old, logic out,
                                      logic anye, logic [1:0] code);
        if (out)          return 1'b0;
        if (anye)         return cur != old;
        if (code[1])      return (cur != old) && (cur != code[0]);
        return cur == code[0];
    endfunction

    // Driver: apply one cycle of stimulus and queue its expectation
    task automatic step(input logic [31:0] p, input logic [31:0] d,
                        input logic [63:0] c, input logic [31:0] b,
                        input logic [31:0] clr, input string tag);
        exp_t it;
        @(negedge clk);
        pin_lvl = p; pin_is_out = d; sense_cfg = c; both_edge = b; sts_clr = clr;
        for (int i = 0; i < 32; i++)
            it.e_set[i] = want_hit(p[i], m_prev[i], d[i], b[i], c[2*i +: 2]);
        it.e_sts = m_sts;
        it.tag = tag;
        exp_q.push_back(it);
        m_prev = p;
        m_sts = (m_sts & ~clr) | it.e_set;
    endtask

    // Monitor: compare outputs just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_total++;
                if (set_pulse !== it.e_set) begin
                    n_bad++;
                    $display("FAIL %s set_pulse act=%h exp=%h", it.tag, set_pulse, it.e_set);
                end
                n_total++;
                if (irq_status !== it.e_sts) begin
                    n_bad++;
                    $display("FAIL %s irq_status act=%h exp=%h", it.tag, irq_status, it.e_sts);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_total++;
        if (irq_status !== '0 || set_pulse !== '0) begin
            n_bad++;
            $display("FAIL R12 reset act=%h/%h exp=0/0", irq_status, set_pulse);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        step(ONES, '0, C_RISE, '0, '0,   "R12 history cleared, rise seen");
        step(ONES, '0, C_RISE, '0, '0,   "R4 steady high no pulse");
        step(ONES, '0, C_RISE, '0, ONES, "R10 clear all");
        step(ONES, '0, C_RISE, '0, '0,   "R10 status dropped");
        step(ONES, ONES, C_HIGH, '0, '0, "R1 output high level code");
        step('0,   ONES, C_HIGH, '0, '0, "R1 output toggles");
        step(ONES, ONES, C_RISE, '0, '0, "R8 output rises");
        step(ONES, '0, C_RISE, '0, '0,   "R8 turn to input no false edge");
        step('0,   '0, C_FALL, '0, '0,   "R5 falling pulses");
        step(ONES, '0, C_FALL, '0, '0,   "R5 rise ignored");
        step(ONES, '0, C_LOW, '0, ONES,  "R6 high is inactive");
        step('0,   '0, C_LOW, '0, '0,    "R6 low pulses");
        step('0,   '0, C_LOW, '0, ONES,  "R10 pulse beats clear");
        step('0,   '0, C_LOW, '0, ONES,  "R11 level re-sets after clear");
        step(ONES, '0, C_LOW, '0, ONES,  "R11 released and cleared");
        step(ONES, '0, C_HIGH, '0, '0,   "R7 high pulses");
        step('0,   '0, C_HIGH, '0, ONES, "R7 low inactive");
        step(ONES, '0, C_LOW, ONES, ONES, "R2 override rise with low code");
        step(ONES, '0, C_HIGH, ONES, ONES, "R3 override steady, high code ignored");
        step('0,   '0, C_RISE, ONES, ONES, "R2 override fall with rise code");
        step(32'h0, '0, 64'hAAAA_AAAA_AAAA_AA4E, '0, ONES, "R9 mixed codes idle");
        step(32'hF, '0, 64'hAAAA_AAAA_AAAA_AA4E, '0, ONES, "R9 mixed codes rise");
        step(32'h0, '0, 64'hAAAA_AAAA_AAAA_AA4E, '0, ONES, "R9 mixed codes fall");
        step(32'h0, 32'h4, 64'hAAAA_AAAA_AAAA_AA4E, '0, ONES, "R1 single output pin");
        step(32'h0, '0, C_RISE, '0, ONES, "R10 final clear");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule